// File: doc/BRIEF.md
# Serial Flash Single-Byte Program Controller

This controller takes one program request from a host (a byte, a 24-bit byte address, a write strobe and an enable qualifier) and carries it out on an SPI NOR flash. It first reads the flash status register and decodes the block-protect field against the target address. It cancels the request if the address is protected. Otherwise it sets the write-enable latch, sends the page-program command with the address and the data byte, and polls status until the internal write cycle ends. The host sees a single `busy` level for the whole job and a two-cycle `illegal_wr` pulse when a request is refused.

A request is taken only in the idle state, on a rising clock edge where both `wr_stb` and `wr_en` are high. After `busy` falls, the controller ignores the host for two cycles. A request still held after those two cycles starts a new job. Setting `rev_bits` with the request programs the data byte with its bit order reversed, for images that are consumed LSB-first.

The state machine has these states. ST_IDLE waits for a request. ST_PROBE_CMD and ST_PROBE_RD read status in one frame. From ST_PROBE_RD the machine goes to ST_DENY if the address is protected, or through ST_GAP to ST_WEN otherwise. ST_WEN sends write enable, then ST_GAP. ST_PROG_CMD, ST_PROG_ADR (one visit per address byte) and ST_PROG_DAT form the program frame, then ST_GAP. ST_POLL_CMD and ST_POLL_RD form one status poll; they go back through ST_GAP while the write-in-progress bit is set, and to ST_RECOVER once it clears. ST_GAP holds chip select high for a fixed time and then enters the state it was given. ST_DENY lasts two cycles and returns to ST_IDLE. ST_RECOVER lasts two cycles and returns to ST_IDLE.

Top module: `sflash_byte_prog`

## Requirements
- R1: While reset is applied and just after it, busy and illegal_wr are low, fl_cs_n is high and fl_sck is low.
- R2: A request starts only if wr_stb and wr_en are both high at a rising edge in idle. Any other combination causes no flash frame and leaves busy low.
- R3: Address, data and rev_bits are captured at the accepting edge. Later changes to these inputs do not alter the bytes sent to the flash.
- R4: busy is high from the cycle after acceptance. It stays high until the status poll that shows the write-in-progress bit (status bit 0) clear, and it falls at the end of that poll.
- R5: An unprotected request produces exactly these frames in order: status read 0x05, write enable 0x06, program 0x02 followed by three address bytes MSB-first and the data byte, then 0x05 polls up to and including the first one that reads bit 0 as 0.
- R6: A protected request sends only the status read frame. busy then falls and illegal_wr is high for exactly two cycles, with busy low throughout.
- R7: The protect field is status bits 4..2 (BP). BP=0 protects nothing and BP=7 protects everything. For any other BP, an address is protected when its bits 20 down to 14+BP are all ones. Address bits above bit 20 are not considered.
- R8: For two cycles after busy falls, requests are ignored. A request held through them is accepted on the next edge, so busy stays low for exactly three cycles before the second job.
- R9: SPI mode 0 is used. fl_sck is low whenever fl_cs_n is high, each fl_sck high phase lasts one clock, fl_mosi changes only while fl_sck is low, and fl_cs_n stays high for at least two clocks between frames.
- R10: With rev_bits high at acceptance, the programmed byte is the data byte with bit 7 swapped with bit 0, bit 6 with bit 1, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write request strobe |
| wr_en | input | 1 | Write enable qualifier; must be high with wr_stb |
| wr_addr | input | 24 | Target byte address |
| wr_data | input | 8 | Byte to program |
| rev_bits | input | 1 | Reverse the data byte's bit order |
| busy | output | 1 | Job in progress |
| illegal_wr | output | 1 | Two-cycle pulse for a refused request |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock, half the system clock |
| fl_mosi | output | 1 | Serial data to flash |
| fl_miso | input | 1 | Serial data from flash |

## Verification
A wrong state transition shows up at the ports within one frame. It appears as a missing or extra opcode in the frame log, a program frame after a protected status read, or a poll loop that stops while the flash still reports write in progress. A stale count in the gap, deny or recovery states appears within a few cycles: the illegal_wr pulse has the wrong length, busy is low for the wrong number of cycles before a held request re-triggers, or chip select goes low too early. Errors in capture or shifting appear as a scoreboard mismatch on the address or data of the program frame.

// File: rtl/sfbp_pkg.sv
package sfbp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE_CMD,
        ST_PROBE_RD,
        ST_WEN,
        ST_PROG_CMD,
        ST_PROG_ADR,
        ST_PROG_DAT,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_GAP,
        ST_DENY,
        ST_RECOVER
    } st_e;

    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;

    // States in which chip select is held low and a byte is shifted
    function automatic logic in_frame(input st_e s);
        return (s inside {ST_PROBE_CMD, ST_PROBE_RD, ST_WEN, ST_PROG_CMD,
                          ST_PROG_ADR, ST_PROG_DAT, ST_POLL_CMD, ST_POLL_RD});
    endfunction

endpackage

// File: rtl/sfbp_spi_byte.sv
module sfbp_spi_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx,
    input  logic         miso,
    output logic         sck,
    output logic         mosi,
    output logic         active,
    output logic         done,
    output logic [W-1:0] rx
);
    localparam int CW = $clog2(W);

    logic          ph;
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh     <= tx;
                    ph     <= 1'b0;
                    cnt    <= '0;
                end
            end else if (!ph) begin
                ph <= 1'b1;
            end else begin
                ph <= 1'b0;
                sh <= {sh[W-2:0], miso};
                if (cnt == CW'(W-1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign sck  = ph;
    assign mosi = sh[W-1];
    assign rx   = sh;

    // R9: data towards the flash is steady across each high phase
    p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sfbp_prot_dec.sv
module sfbp_prot_dec #(
    parameter int ARR_AW = 21,
    parameter int BPW    = 3
) (
    input  logic [BPW-1:0]    bp,
    input  logic [ARR_AW-1:0] addr,
    output logic              prot
);
    localparam int FULL = (1 << BPW) - 1;

    always_comb begin
        if (bp == '0) begin
            prot = 1'b0;
        end else if (bp == BPW'(FULL)) begin
            prot = 1'b1;
        end else begin
            prot = 1'b1;
            for (int i = 0; i < FULL; i++) begin
                if (i < FULL - int'(bp)) prot = prot & addr[ARR_AW-1-i];
            end
        end
    end

endmodule

// File: rtl/sflash_byte_prog.sv
module sflash_byte_prog
    import sfbp_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 8,
    parameter int ARR_AW    = 21,
    parameter int BP_LSB    = 2,
    parameter int GAP_CYC   = 2,
    parameter int DENY_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rev_bits,
    output logic          busy,
    output logic          illegal_wr,
    output logic          fl_cs_n,
    output logic          fl_sck,
    output logic          fl_mosi,
    input  logic          fl_miso
);
    localparam int NAB   = AW / 8;
    localparam int MAX1  = (GAP_CYC > DENY_CYC) ? GAP_CYC : DENY_CYC;
    localparam int MAX2  = (MAX1 > RECOV_CYC) ? MAX1 : RECOV_CYC;
    localparam int MAXC  = (MAX2 > NAB) ? MAX2 : NAB;
    localparam int CNTW  = $clog2(MAXC + 1);

    st_e             st, st_n, ret, ret_n;
    logic [CNTW-1:0] cnt, cnt_n;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   data_q, data_rev;
    logic            accept;

    logic            sh_start, sh_act, sh_done;
    logic [7:0]      sh_tx, sh_rx;
    logic            prot;

    // Bit-order reversal of the incoming byte
    for (genvar g = 0; g < DW; g++) begin : g_rev
        assign data_rev[g] = wr_data[DW-1-g];
    end

    assign accept = (st == ST_IDLE) && wr_stb && wr_en;

    sfbp_spi_byte #(.W(8)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .tx     (sh_tx),
        .miso   (fl_miso),
        .sck    (fl_sck),
        .mosi   (fl_mosi),
        .active (sh_act),
        .done   (sh_done),
        .rx     (sh_rx)
    );

    sfbp_prot_dec #(.ARR_AW(ARR_AW), .BPW(3)) u_prot (
        .bp   (sh_rx[BP_LSB +: 3]),
        .addr (addr_q[ARR_AW-1:0]),
        .prot (prot)
    );

    // Byte to shift in the current state
    always_comb begin
        sh_tx = '0;
        unique case (st)
            ST_PROBE_CMD, ST_POLL_CMD: sh_tx = OP_RDSR;
            ST_WEN:                    sh_tx = OP_WREN;
            ST_PROG_CMD:               sh_tx = OP_PROG;
            ST_PROG_ADR:               sh_tx = addr_q[(NAB-1-int'(cnt))*8 +: 8];
            ST_PROG_DAT:               sh_tx = data_q;
            default:                   sh_tx = '0;
        endcase
    end

    assign sh_start = in_frame(st) && !sh_act && !sh_done;

    // Next-state logic
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        ret_n = ret;
        unique case (st)
            ST_IDLE:      if (accept) st_n = ST_PROBE_CMD;
            ST_PROBE_CMD: if (sh_done) st_n = ST_PROBE_RD;
            ST_PROBE_RD:  if (sh_done) begin
                              cnt_n = '0;
                              if (prot) st_n = ST_DENY;
                              else begin st_n = ST_GAP; ret_n = ST_WEN; end
                          end
            ST_WEN:       if (sh_done) begin st_n = ST_GAP; ret_n = ST_PROG_CMD; cnt_n = '0; end
            ST_PROG_CMD:  if (sh_done) begin st_n = ST_PROG_ADR; cnt_n = '0; end
            ST_PROG_ADR:  if (sh_done) begin
                              if (cnt == CNTW'(NAB-1)) begin st_n = ST_PROG_DAT; cnt_n = '0; end
                              else cnt_n = cnt + 1'b1;
                          end
            ST_PROG_DAT:  if (sh_done) begin st_n = ST_GAP; ret_n = ST_POLL_CMD; cnt_n = '0; end
            ST_POLL_CMD:  if (sh_done) st_n = ST_POLL_RD;
            ST_POLL_RD:   if (sh_done) begin
                              cnt_n = '0;
                              if (sh_rx[0]) begin st_n = ST_GAP; ret_n = ST_POLL_CMD; end
                              else st_n = ST_RECOVER;
                          end
            ST_GAP:       if (cnt == CNTW'(GAP_CYC-1)) begin st_n = ret; cnt_n = '0; end
                          else cnt_n = cnt + 1'b1;
            ST_DENY:      if (cnt == CNTW'(DENY_CYC-1)) begin st_n = ST_IDLE; cnt_n = '0; end
                          else cnt_n = cnt + 1'b1;
            ST_RECOVER:   if (cnt == CNTW'(RECOV_CYC-1)) begin st_n = ST_IDLE; cnt_n = '0; end
                          else cnt_n = cnt + 1'b1;
            default:      st_n = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ret    <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st  <= st_n;
            ret <= ret_n;
            cnt <= cnt_n;
            if (accept) begin
                addr_q <= wr_addr;
                data_q <= rev_bits ? data_rev : wr_data;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            illegal_wr <= 1'b0;
            fl_cs_n    <= 1'b1;
        end else begin
            busy       <= !(st_n inside {ST_IDLE, ST_DENY, ST_RECOVER});
            illegal_wr <= (st_n == ST_DENY);
            fl_cs_n    <= !in_frame(st_n);
        end
    end

    // R6: refusal pulse lasts exactly two cycles, busy low meanwhile
    p_illegal_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_wr) |=> illegal_wr);
    p_illegal_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_wr && $past(illegal_wr)) |=> !illegal_wr);
    p_illegal_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_wr |-> !busy);
    // R2: no job without both strobe and qualifier
    p_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(wr_stb && wr_en)) |=> !busy);
    // R8: at least the cycle after busy falls stays quiet
    p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !busy);
    // R9: chip select gap and idle serial clock
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_cs_n) |=> fl_cs_n);
    p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cs_n |-> !fl_sck);
    // R7: a zero protect field never leads to a refusal
    p_bp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROBE_RD && sh_done && sh_rx[BP_LSB +: 3] == 3'd0) |=> st == ST_GAP);

endmodule

// File: tb/sflash_byte_prog_tb.sv
module sflash_byte_prog_tb;
    localparam int CLK_P    = 10;
    localparam int WIP_POLL = 3;
    localparam int WDOG     = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0, wr_en = 1'b0, rev_bits = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, illegal_wr, fl_cs_n, fl_sck, fl_mosi;
    logic        fl_miso = 1'b0;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    sflash_byte_prog u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rev_bits(rev_bits),
        .busy(busy), .illegal_wr(illegal_wr), .fl_cs_n(fl_cs_n),
        .fl_sck(fl_sck), .fl_mosi(fl_mosi), .fl_miso(fl_miso)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [2:0]  bp_cfg = '0;
    logic        wel = 1'b0;
    int          wip_left = 0, rd_since_prog = 0;
    int          bitcnt = 0, nbytes = 0, nframes = 0;
    logic [7:0]  shin = '0, stat_snap = '0;
    logic [7:0]  fb [0:7];
    logic [7:0]  ops [$];
    logic [31:0] exp_q [$];
    bit          timing_ok = 1;
    time         t_rise = 0, t_csr = 0;

    always @(negedge fl_cs_n) begin
        if (rst_n && t_csr != 0 && ($time - t_csr) < 2*CLK_P) timing_ok = 0;
        bitcnt = 0; nbytes = 0;
        stat_snap = {3'b000, bp_cfg, wel, (wip_left > 0)};
    end

    always @(posedge fl_sck) begin
        t_rise = $time;
        shin = {shin[6:0], fl_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0 && nbytes < 8) begin fb[nbytes] = shin; nbytes++; end
    end

    always @(negedge fl_sck) begin
        if ($time - t_rise != CLK_P) timing_ok = 0;
        if (bitcnt >= 8 && bitcnt < 16 && fb[0] == 8'h05) #1 fl_miso = stat_snap[15-bitcnt];
    end

    // Monitor: pops the scoreboard at each program frame
    always @(posedge fl_cs_n) begin
        t_csr = $time;
        if (rst_n && nbytes > 0) begin
            nframes++;
            ops.push_back(fb[0]);
            if (fb[0] == 8'h05) begin
                rd_since_prog++;
                if (wip_left > 0) wip_left--;
            end else if (fb[0] == 8'h06) begin
                wel = 1'b1;
            end else if (fb[0] == 8'h02 && nbytes == 5 && wel) begin
                logic [31:0] got;
                got = {fb[1], fb[2], fb[3], fb[4]};
                if (exp_q.size() == 0) chk(0, "R5 unexpected program", got, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R3/R5/R10 program addr+data", got, e);
                end
                wip_left = WIP_POLL; wel = 1'b0; rd_since_prog = 0;
            end
        end
    end

    // R4: busy falls only after the poll that saw the write finished
    always @(negedge busy) begin
        #1;
        if (rst_n && !illegal_wr)
            chk(wip_left == 0 && rd_since_prog == WIP_POLL + 1, "R4 busy fall vs polls",
                32'(rd_since_prog), 32'(WIP_POLL + 1));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- driver ----------------
    function automatic logic [7:0] rev8(input logic [7:0] d);
        for (int i = 0; i < 8; i++) rev8[i] = d[7-i];
    endfunction

    task automatic issue(input logic [23:0] a, input logic [7:0] d, input bit rv, input bit expect_prog);
        if (expect_prog) exp_q.push_back({a, rv ? rev8(d) : d});
        @(negedge clk);
        wr_addr = a; wr_data = d; rev_bits = rv; wr_stb = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; wr_en = 1'b0; wr_addr = ~a; wr_data = ~d; rev_bits = ~rv;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy && !illegal_wr) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic normal_write(input logic [23:0] a, input logic [7:0] d, input bit rv, input string req);
        ops.delete();
        issue(a, d, rv, 1);
        chk(busy == 1'b1, {req, " R4 busy after accept"}, 32'(busy), 32'h1);
        wait_quiet();
        chk(ops.size() == 3 + WIP_POLL + 1, {req, " R5 frame count"}, 32'(ops.size()), 32'(3 + WIP_POLL + 1));
        if (ops.size() == 3 + WIP_POLL + 1) begin
            bit seq_ok;
            seq_ok = (ops[0] == 8'h05) && (ops[1] == 8'h06) && (ops[2] == 8'h02);
            for (int i = 3; i < ops.size(); i++) seq_ok &= (ops[i] == 8'h05);
            chk(seq_ok, {req, " R5 opcode order"}, {ops[0], ops[1], ops[2], ops[3]}, 32'h05060205);
        end
    endtask

    task automatic refused_write(input logic [23:0] a, input string req);
        int ill_cyc, busy_ill;
        ops.delete();
        ill_cyc = 0; busy_ill = 0;
        issue(a, 8'h5A, 0, 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (illegal_wr) begin ill_cyc++; if (busy) busy_ill++; end
        end
        chk(ill_cyc == 2, {req, " R6 illegal pulse length"}, 32'(ill_cyc), 32'd2);
        chk(busy_ill == 0 && !busy, {req, " R6 busy low"}, 32'(busy_ill), 32'd0);
        chk(ops.size() == 1 && ops[0] == 8'h05, {req, " R6 only status read"}, 32'(ops.size()), 32'd1);
    endtask

    initial begin
        int f0, lowc;
        repeat (3) @(negedge clk);
        chk(!busy && !illegal_wr && fl_cs_n && !fl_sck, "R1 during reset",
            {busy, illegal_wr, fl_cs_n, fl_sck}, 4'b0010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !illegal_wr && fl_cs_n && !fl_sck, "R1 after reset",
            {busy, illegal_wr, fl_cs_n, fl_sck}, 4'b0010);

        // R2: strobe without qualifier, qualifier without strobe
        f0 = nframes;
        wr_stb = 1'b1; wr_en = 1'b0; repeat (10) @(negedge clk);
        chk(!busy, "R2 strobe only busy", 32'(busy), 32'h0);
        wr_stb = 1'b0; wr_en = 1'b1; repeat (10) @(negedge clk);
        wr_en = 1'b0; repeat (4) @(negedge clk);
        chk(!busy && nframes == f0, "R2 no frames", 32'(nframes - f0), 32'h0);

        bp_cfg = 3'd0;
        normal_write(24'h123456, 8'hA5, 0, "R5 basic");
        normal_write(24'hFFFFFF, 8'h00, 0, "R7 bp0 top");
        normal_write(24'h00AB01, 8'h1E, 1, "R10 reversed");

        bp_cfg = 3'd6;
        refused_write(24'h1FFFFF, "R7 bp6 upper half");
        normal_write(24'h0FFFFF, 8'h3C, 0, "R7 bp6 lower half");
        normal_write(24'hE00000, 8'h77, 0, "R7 bp6 high bits ignored");
        bp_cfg = 3'd1;
        refused_write(24'h1F8000, "R7 bp1 top 1/64");
        normal_write(24'h1F0000, 8'h81, 0, "R7 bp1 below range");
        bp_cfg = 3'd7;
        refused_write(24'h000000, "R7 bp7 all");
        bp_cfg = 3'd0;

        // R8: held request re-triggers after exactly three low cycles
        exp_q.push_back({24'h000100, 8'h11});
        exp_q.push_back({24'h000100, 8'h11});
        @(negedge clk);
        wr_addr = 24'h000100; wr_data = 8'h11; rev_bits = 0; wr_stb = 1; wr_en = 1;
        for (int i = 0; i < 5000 && !busy; i++) @(negedge clk);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        lowc = 0;
        for (int i = 0; i < 20 && !busy; i++) begin lowc++; @(negedge clk); end
        wr_stb = 0; wr_en = 0;
        chk(lowc == 3, "R8 held request low gap", 32'(lowc), 32'd3);
        wait_quiet();

        // R8: a one-cycle request in either recovery cycle is dropped
        for (int k = 0; k < 2; k++) begin
            issue(24'h000200, 8'h22, 0, 1);
            for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
            if (k == 1) @(negedge clk);
            f0 = nframes;
            wr_stb = 1; wr_en = 1; wr_addr = 24'h000300;
            @(negedge clk);
            wr_stb = 0; wr_en = 0;
            repeat (12) @(negedge clk);
            chk(!busy && nframes == f0, "R8 request in recovery ignored", 32'(nframes - f0), 32'h0);
        end

        chk(exp_q.size() == 0, "R5 all expected programs seen", 32'(exp_q.size()), 32'h0);
        chk(timing_ok, "R9 sck phase and cs gap", 32'(timing_ok), 32'h1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule